// File: doc/BRIEF.md
# Serial Command and Display-Data Interpreter

This block sits behind a byte-level I2C slave engine and turns the byte stream that follows the slave address into register updates and display-memory traffic. A write transfer opens with one or more control bytes. Bit 7 of each control byte tells the block whether another control byte follows, or whether every remaining byte of the transfer is display data. Control bytes set the display mode, the first memory bank shown, the data pointer and the device subaddress. Display data bytes are written to memory at an auto-incrementing pointer.

A read transfer returns memory bytes from the same pointer. The first byte is fetched as soon as the read transfer starts. Each following byte is fetched while the previous one is being shifted out, so the byte engine never waits at an acknowledge. Memory strobes are only issued when the block is in mixed row/column mode and the current subaddress equals the block's own hardware subaddress. The pointer advances on every data byte either way, so a write or read stream can run on across a chain of cascaded devices.

The byte engine supplies START, STOP, the read/write bit, received bytes and requests for the next transmit byte. The block drives a simple synchronous memory port and a set of mode outputs.

Top module: `lcd_cmd_interp`

## Requirements
- R1: After reset the multiplex code is 2'b11 (1:32), the display code is 2'b00 (blank), the start bank is 0, the block is in row-only mode (mixed_o=0), the subaddress is 0 and the pointer (ram_addr_o) is 0.
- R2: Bit 7 of a control byte set to 1 makes the next byte a control byte. Bit 7 set to 0 makes every later byte of the transfer display data, and display data is never decoded as a command even when its bit 7 is 1.
- R3: A control byte with bits[6:5]=2'b10 is a set-mode command. Bit 4 selects mixed mode (1) or row-only mode (0), bits[3:2] are the multiplex code and bits[1:0] are the display code.
- R4: A control byte with bits[6:4]=3'b110 loads bits[3:0] into the subaddress. A control byte with bits[6:2]=5'b11100 loads bits[1:0] into the start bank.
- R5: A control byte with bit 6 = 0 loads the pointer with {bits[5:0],2'b00}. The load is ignored when that value is 160 or more.
- R6: A control byte with bits[6:3]=4'b1111 or bits[6:2]=5'b11101 changes no register. Its bit 7 still decides whether the next byte is control or data.
- R7: Each display data byte of a write transfer is written at ram_addr_o, and the pointer then increments by 1.
- R8: The pointer wraps from 159 to 0, and on that wrap the subaddress increments by 1.
- R9: ram_we_o and ram_re_o are asserted only when mixed_o=1 and the subaddress equals 0. The pointer still advances on every data byte when the strobes are suppressed.
- R10: A START with the read bit set fetches the byte at the pointer, and tx_byte_o holds it two cycles after the fetch request. Each tx_take_i pulse fetches the next byte. A fetch with the strobe suppressed places 8'hFF in tx_byte_o.
- R11: A tx_nack_i pulse ends the read transfer, and no later tx_take_i pulse fetches a byte or moves the pointer.
- R12: A START always returns the block to expecting a control byte, even in the middle of a control sequence. After a STOP, received bytes neither write memory nor change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START (or repeated START) seen, one-cycle pulse |
| stop_i | input | 1 | STOP seen, one-cycle pulse |
| rnw_i | input | 1 | Read/write bit of the address, valid with start_i |
| rx_vld_i | input | 1 | Received byte valid, one-cycle pulse |
| rx_byte_i | input | 8 | Received byte |
| tx_take_i | input | 1 | Engine has loaded tx_byte_o into its shifter and wants the next byte |
| tx_nack_i | input | 1 | Master did not acknowledge, read ends |
| ram_we_o | output | 1 | Memory write strobe |
| ram_re_o | output | 1 | Memory read strobe, data returned next cycle |
| ram_addr_o | output | 8 | Memory address (current pointer) |
| ram_wdata_o | output | 8 | Memory write data |
| ram_rdata_i | input | 8 | Memory read data |
| tx_byte_o | output | 8 | Next byte for the transmit shifter |
| mux_rate_o | output | 2 | Multiplex code: 00 1:8, 01 1:16, 10 1:24, 11 1:32 |
| disp_ctl_o | output | 2 | Display code, 00 = blank |
| start_bank_o | output | 2 | Memory bank shown at the top of the display |
| mixed_o | output | 1 | 1 = mixed row/column mode, 0 = row-only mode |
| subaddr_o | output | 4 | Current subaddress |

## Verification
The bench targets the points where the control/data boundary can slip. A byte following a continue bit of 1 has to update a register. Data bytes with bit 7 set must not be decoded, and a design that decoded them would jump the pointer. A repeated START arriving in the middle of a control sequence has to restart decoding. The bench drives the pointer across 159 so that a missing subaddress increment shows up as a stray memory write. It also loads an out-of-range pointer value, which a design without the range check would accept. Read tests cover the prefetch timing, the 8'hFF fill for a foreign subaddress, and the rule that no fetch follows a NACK. A design that prefetched after a NACK would show an extra read strobe and a moved pointer.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CTRL  = 2'd1,
    ST_WDATA = 2'd2,
    ST_RDATA = 2'd3
  } dec_state_t;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PTR    = 3'd1,
    OP_MODE   = 3'd2,
    OP_DEVSEL = 3'd3,
    OP_BANK   = 3'd4
  } ctrl_op_t;

  // Opcode field of a control byte (bits 6:0)
  function automatic ctrl_op_t op_decode(input logic [6:0] b);
    if (!b[6])                  return OP_PTR;
    else if (b[5] == 1'b0)      return OP_MODE;
    else if (b[4] == 1'b0)      return OP_DEVSEL;
    else if (b[3:2] == 2'b00)   return OP_BANK;
    else                        return OP_NONE;
  endfunction

  // Pointer value carried by a load-pointer byte
  function automatic logic [7:0] ptr_field(input logic [6:0] b);
    return {b[5:0], 2'b00};
  endfunction

endpackage

// File: rtl/lcd_addr_gen.sv
module lcd_addr_gen #(
  parameter int DEPTH = 160,
  parameter int SUB_W = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_ptr,
  input  logic [AW-1:0]    ld_ptr_val,
  input  logic             ld_sub,
  input  logic [SUB_W-1:0] ld_sub_val,
  input  logic             adv,
  output logic [AW-1:0]    ptr_o,
  output logic [SUB_W-1:0] sub_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // {wrap, next pointer}
  function automatic logic [AW:0] ptr_step(input logic [AW-1:0] p);
    if (p == LAST) return {1'b1, {AW{1'b0}}};
    else           return {1'b0, p + AW'(1)};
  endfunction

  logic [AW:0] step;
  logic        wrap_evt;

  assign step     = ptr_step(ptr_o);
  assign wrap_evt = adv && step[AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o <= '0;
      sub_o <= '0;
    end else begin
      if (ld_ptr)   ptr_o <= ld_ptr_val;
      else if (adv) ptr_o <= step[AW-1:0];
      if (ld_sub)        sub_o <= ld_sub_val;
      else if (wrap_evt) sub_o <= sub_o + SUB_W'(1);
    end
  end

  a_r7_ptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld_ptr && ptr_o != LAST) |=> (int'(ptr_o) == int'($past(ptr_o)) + 1));

  a_r8_wrap_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld_sub && ptr_o == LAST) |=> (ptr_o == '0 && sub_o == $past(sub_o) + SUB_W'(1)));

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_o) < DEPTH);

endmodule

// File: rtl/lcd_cmd_dec.sv
module lcd_cmd_dec
  import lcd_cmd_pkg::*;
#(
  parameter int DEPTH = 160,
  parameter int SUB_W = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rnw_i,
  input  logic             rx_vld_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_take_i,
  input  logic             tx_nack_i,
  input  logic             access_ok,
  input  logic [7:0]       ram_rdata_i,
  output logic             ld_ptr,
  output logic [AW-1:0]    ld_ptr_val,
  output logic             ld_sub,
  output logic [SUB_W-1:0] ld_sub_val,
  output logic             data_adv,
  output logic             ram_we_o,
  output logic             ram_re_o,
  output logic [7:0]       tx_byte_o,
  output logic [1:0]       mux_rate_o,
  output logic [1:0]       disp_ctl_o,
  output logic [1:0]       start_bank_o,
  output logic             mixed_o
);

  dec_state_t state_q, state_d;
  logic       rd_first_q, rd_pend_q, rd_hit_q;
  logic       bus_evt;
  logic       ev_ctrl, ev_wdata, ev_fetch;
  ctrl_op_t   op;
  logic [7:0] ld_raw;

  assign bus_evt  = start_i || stop_i;
  assign ev_ctrl  = (state_q == ST_CTRL)  && rx_vld_i && !bus_evt;
  assign ev_wdata = (state_q == ST_WDATA) && rx_vld_i && !bus_evt;
  assign ev_fetch = (state_q == ST_RDATA) && !bus_evt && !tx_nack_i &&
                    (rd_first_q || tx_take_i);

  assign op         = op_decode(rx_byte_i[6:0]);
  assign ld_raw     = ptr_field(rx_byte_i[6:0]);
  assign ld_ptr     = ev_ctrl && (op == OP_PTR) && (int'(ld_raw) < DEPTH);
  assign ld_ptr_val = AW'(ld_raw);
  assign ld_sub     = ev_ctrl && (op == OP_DEVSEL);
  assign ld_sub_val = SUB_W'(rx_byte_i[3:0]);

  assign data_adv = ev_wdata || ev_fetch;
  assign ram_we_o = ev_wdata && access_ok;
  assign ram_re_o = ev_fetch && access_ok;

  always_comb begin
    state_d = state_q;
    if (start_i)                               state_d = rnw_i ? ST_RDATA : ST_CTRL;
    else if (stop_i)                           state_d = ST_IDLE;
    else if (ev_ctrl && !rx_byte_i[7])         state_d = ST_WDATA;
    else if (state_q == ST_RDATA && tx_nack_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      rd_first_q   <= 1'b0;
      rd_pend_q    <= 1'b0;
      rd_hit_q     <= 1'b0;
      tx_byte_o    <= 8'hFF;
      mux_rate_o   <= 2'b11;
      disp_ctl_o   <= 2'b00;
      start_bank_o <= 2'b00;
      mixed_o      <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_pend_q <= ev_fetch;
      rd_hit_q  <= ram_re_o;
      if (start_i)       rd_first_q <= rnw_i;
      else if (stop_i || ev_fetch) rd_first_q <= 1'b0;
      if (rd_pend_q) tx_byte_o <= rd_hit_q ? ram_rdata_i : 8'hFF;
      if (ev_ctrl && op == OP_MODE) begin
        mixed_o    <= rx_byte_i[4];
        mux_rate_o <= rx_byte_i[3:2];
        disp_ctl_o <= rx_byte_i[1:0];
      end
      if (ev_ctrl && op == OP_BANK) start_bank_o <= rx_byte_i[1:0];
    end
  end

  a_r12_start_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_CTRL || state_q == ST_RDATA));

  a_r12_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && !ram_we_o && !ram_re_o));

  a_r2_last_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ctrl && !rx_byte_i[7]) |=> (state_q == ST_WDATA));

  a_r2_no_decode_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDATA && !start_i) |=> $stable(mux_rate_o) && $stable(start_bank_o));

  a_r11_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDATA && tx_nack_i && !start_i) |=> !ram_re_o);

  a_r10_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fetch && !access_ok) |=> ##1 (tx_byte_o == 8'hFF));

endmodule

// File: rtl/lcd_cmd_interp.sv
module lcd_cmd_interp #(
  parameter int DEPTH  = 160,
  parameter int SUB_W  = 4,
  parameter int HW_SUB = 0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rnw_i,
  input  logic             rx_vld_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_take_i,
  input  logic             tx_nack_i,
  output logic             ram_we_o,
  output logic             ram_re_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [7:0]       ram_wdata_o,
  input  logic [7:0]       ram_rdata_i,
  output logic [7:0]       tx_byte_o,
  output logic [1:0]       mux_rate_o,
  output logic [1:0]       disp_ctl_o,
  output logic [1:0]       start_bank_o,
  output logic             mixed_o,
  output logic [SUB_W-1:0] subaddr_o
);

  logic             ld_ptr, ld_sub, data_adv, access_ok;
  logic [AW-1:0]    ld_ptr_val;
  logic [SUB_W-1:0] ld_sub_val;

  assign access_ok   = mixed_o && (subaddr_o == SUB_W'(HW_SUB));
  assign ram_wdata_o = rx_byte_i;

  lcd_cmd_dec #(.DEPTH(DEPTH), .SUB_W(SUB_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .stop_i(stop_i), .rnw_i(rnw_i),
    .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i),
    .tx_take_i(tx_take_i), .tx_nack_i(tx_nack_i),
    .access_ok(access_ok), .ram_rdata_i(ram_rdata_i),
    .ld_ptr(ld_ptr), .ld_ptr_val(ld_ptr_val),
    .ld_sub(ld_sub), .ld_sub_val(ld_sub_val),
    .data_adv(data_adv),
    .ram_we_o(ram_we_o), .ram_re_o(ram_re_o), .tx_byte_o(tx_byte_o),
    .mux_rate_o(mux_rate_o), .disp_ctl_o(disp_ctl_o),
    .start_bank_o(start_bank_o), .mixed_o(mixed_o)
  );

  lcd_addr_gen #(.DEPTH(DEPTH), .SUB_W(SUB_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .ld_ptr(ld_ptr), .ld_ptr_val(ld_ptr_val),
    .ld_sub(ld_sub), .ld_sub_val(ld_sub_val),
    .adv(data_adv),
    .ptr_o(ram_addr_o), .sub_o(subaddr_o)
  );

  a_r9_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o || ram_re_o) |-> (mixed_o && subaddr_o == SUB_W'(HW_SUB)));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we_o && ram_re_o));

  a_r7_write_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && !start_i && !stop_i) |=> (ram_addr_o != $past(ram_addr_o)));

endmodule

// File: tb/sim_lcd_cmd_interp.sv
module sim_lcd_cmd_interp;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, stop_i = 0, rnw_i = 0, rx_vld_i = 0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       tx_take_i = 0, tx_nack_i = 0;
  logic       ram_we_o, ram_re_o;
  logic [7:0] ram_addr_o, ram_wdata_o, tx_byte_o;
  logic [7:0] ram_rdata_i = 8'h00;
  logic [1:0] mux_rate_o, disp_ctl_o, start_bank_o;
  logic       mixed_o;
  logic [3:0] subaddr_o;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, re_cnt = 0;
  logic [7:0] mem [0:159];
  bit finished = 0;

  always #2 clk = ~clk;

  lcd_cmd_interp u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .rnw_i(rnw_i),
    .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i), .tx_take_i(tx_take_i),
    .tx_nack_i(tx_nack_i), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .tx_byte_o(tx_byte_o), .mux_rate_o(mux_rate_o), .disp_ctl_o(disp_ctl_o),
    .start_bank_o(start_bank_o), .mixed_o(mixed_o), .subaddr_o(subaddr_o)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (ram_we_o) begin mem[ram_addr_o] <= ram_wdata_o; wr_cnt <= wr_cnt + 1; end
    if (ram_re_o) begin ram_rdata_i <= mem[ram_addr_o]; re_cnt <= re_cnt + 1; end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic rw);
    @(negedge clk); start_i = 1; rnw_i = rw;
    @(negedge clk); start_i = 0; rnw_i = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask
  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_vld_i = 1; rx_byte_i = b;
    @(negedge clk); rx_vld_i = 0;
  endtask
  task automatic take();
    @(negedge clk); tx_take_i = 1;
    @(negedge clk); tx_take_i = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 mux", mux_rate_o, 3);
    check("R1 disp", disp_ctl_o, 0);
    check("R1 bank", start_bank_o, 0);
    check("R1 mixed", mixed_o, 0);
    check("R1 sub", subaddr_o, 0);
    check("R1 ptr", ram_addr_o, 0);
  endtask

  task automatic t_row_mode();
    do_start(0); put(8'h00); put(8'hA5); do_stop();
    check("R9 no write in row mode", wr_cnt, 0);
    check("R9 ptr advances", ram_addr_o, 1);
  endtask

  task automatic t_mode_data();
    do_start(0);
    put(8'hD9);
    check("R3 mixed", mixed_o, 1);
    check("R3 mux", mux_rate_o, 2);
    check("R3 disp", disp_ctl_o, 1);
    put(8'hF2);
    check("R2 R4 bank after continue", start_bank_o, 2);
    put(8'h02);
    check("R5 ptr load", ram_addr_o, 8);
    put(8'h91); put(8'h22); put(8'hE3);
    do_stop();
    check("R7 mem8", mem[8], 8'h91);
    check("R7 mem9", mem[9], 8'h22);
    check("R7 mem10", mem[10], 8'hE3);
    check("R2 data not decoded", ram_addr_o, 11);
    check("R2 mode held", mux_rate_o, 2);
    check("R7 write count", wr_cnt, 3);
  endtask

  task automatic t_unknown();
    do_start(0); put(8'hF5); put(8'h7A); put(8'h5A); do_stop();
    check("R6 mux", mux_rate_o, 2);
    check("R6 disp", disp_ctl_o, 1);
    check("R6 bank", start_bank_o, 2);
    check("R6 sub", subaddr_o, 0);
    check("R6 last bit ends ctrl", mem[11], 8'h5A);
    check("R6 ptr", ram_addr_o, 12);
  endtask

  task automatic t_wrap();
    int w0;
    w0 = wr_cnt;
    do_start(0);
    put(8'hA8);
    check("R5 out-of-range ignored", ram_addr_o, 12);
    put(8'h27);
    check("R5 ptr 156", ram_addr_o, 156);
    put(8'h44); put(8'h55); put(8'h66); put(8'h77); put(8'h88);
    do_stop();
    check("R8 mem159", mem[159], 8'h77);
    check("R8 R9 writes before wrap only", wr_cnt - w0, 4);
    check("R8 sub incremented", subaddr_o, 1);
    check("R8 ptr wrapped", ram_addr_o, 1);
    do_start(0); put(8'h60); do_stop();
    check("R4 devsel 0", subaddr_o, 0);
  endtask

  task automatic t_read();
    do_start(0); put(8'h02); do_stop();
    do_start(1);
    @(negedge clk); @(negedge clk);
    check("R10 first byte", tx_byte_o, 8'h91);
    take(); check("R10 second byte", tx_byte_o, 8'h22);
    take(); check("R10 third byte", tx_byte_o, 8'hE3);
    @(negedge clk); tx_nack_i = 1;
    @(negedge clk); tx_nack_i = 0;
    take();
    check("R11 no fetch after nack", re_cnt, 3);
    check("R11 ptr held", ram_addr_o, 11);
    do_stop();
    do_start(0); put(8'h63); do_stop();
    check("R4 devsel 3", subaddr_o, 3);
    do_start(1);
    @(negedge clk); @(negedge clk);
    check("R10 R9 foreign fill", tx_byte_o, 8'hFF);
    check("R9 no read strobe", re_cnt, 3);
    check("R9 ptr advances on read", ram_addr_o, 12);
    do_stop();
  endtask

  task automatic t_restart();
    int w0;
    do_start(0); put(8'h60); do_stop();
    w0 = wr_cnt;
    do_start(0); put(8'h82);
    do_start(0); put(8'h5C);
    check("R12 restart decodes ctrl", mux_rate_o, 3);
    check("R12 disp", disp_ctl_o, 0);
    check("R12 ptr", ram_addr_o, 8);
    do_stop();
    put(8'h12);
    check("R12 no write after stop", wr_cnt - w0, 0);
    check("R12 ptr after stop", ram_addr_o, 8);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_row_mode();
    t_mode_data();
    t_unknown();
    t_wrap();
    t_read();
    t_restart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule